// File: doc/BRIEF.md
# Packet Block Segmenter with Per-Packet Contexts

This block takes packets arriving as a byte stream from several input ports and carves each packet into fixed blocks of 64 bytes. A packet receives one processing context from a fixed pool when its first byte is taken. Each of its blocks is taken from a pool of free block slots, and each block is linked to the one after it, so that a packet is a chain of slots rather than a contiguous region. For every finished block the segmenter issues one descriptor. The descriptor gives the slot, the context, the input port, the packet byte offset of the block start, whether it is the final block, how many bytes it holds, and the slot that follows it. No payload bytes are stored here. The descriptors drive whatever memory holds the data.

Bytes of different ports may be mixed cycle by cycle. Each port has at most one open packet, and that packet holds one context. When a context or a block slot is needed and none is free, the block lowers `in_ready` and holds the byte. It never drops it. A second pass reads a finished packet back. The consumer names a context, and the block presents the chain slot by slot under a valid/acknowledge handshake. When the final slot is acknowledged, the context and all its slots go back to their pools.

Top module: `pdu_blk_seg`

## Requirements
- R1: After reset, `d_valid` and `rp_valid` are low and a start-of-packet byte is accepted (`in_ready` high), because every context and block slot is free.
- R2: Every block that fills with 64 bytes before the end of its packet produces one descriptor with `d_cnt`=64, `d_last`=0 and `d_off`=64·k, where k is the block's position in its packet (k starts at 0). The descriptor appears in the cycle after the byte that completed the block.
- R3: The byte marked end-of-packet produces a descriptor with `d_last`=1, `d_next`=0 and `d_cnt` = ((length−1) mod 64)+1, which is always in the range 1..64.
- R4: A start-of-packet byte takes the lowest-numbered free context. Every descriptor of that packet carries this context and the packet's input port.
- R5: Block slots are taken lowest-numbered free first. The `d_next` of a non-final descriptor equals the `d_blk` of the packet's following descriptor.
- R6: Packets on different ports that are interleaved byte by byte are segmented independently, each in its own context.
- R7: A start-of-packet byte while no context is free is held with `in_ready` low, and no descriptor is emitted while it is held.
- R8: A byte that would complete a block while no block slot is free is held with `in_ready` low, even if it ends the packet.
- R9: A replay request (`rp_start` with `rp_ctx`) for a finished packet raises `rp_valid` in the next cycle. The request presents the head slot and the packet's port. Each `rp_ack` advances along the chain. `rp_last` marks the final slot, and `rp_blk` holds steady until it is acknowledged.
- R10: A context and its slots stay allocated until the final replayed slot is acknowledged, and they are free again in the following cycle. The lowest-first rule then reuses them.
- R11: A replay request for a context that is free or still receiving its packet is ignored, and `rp_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is offered this cycle |
| in_sop | input | 1 | Offered byte is the first of a packet |
| in_eop | input | 1 | Offered byte is the last of a packet |
| in_port | input | PW | Input port of the offered byte |
| in_ready | output | 1 | Offered byte is accepted this cycle |
| d_valid | output | 1 | Descriptor is valid (one-cycle pulse) |
| d_blk | output | BW | Block slot of this block |
| d_ctx | output | CW | Context of the owning packet |
| d_port | output | PW | Input port of the owning packet |
| d_off | output | OFF_W | Packet byte offset of the block start |
| d_last | output | 1 | Final block of the packet |
| d_cnt | output | KW | Valid bytes in the block, 1..64 |
| d_next | output | BW | Following block slot, 0 for the final block |
| rp_start | input | 1 | Start replay of context `rp_ctx` |
| rp_ctx | input | CW | Context to replay |
| rp_ack | input | 1 | Consumer takes the presented slot |
| rp_valid | output | 1 | A replay slot is presented |
| rp_blk | output | BW | Presented slot |
| rp_last | output | 1 | Presented slot is the packet's final one |
| rp_port | output | PW | Input port recorded in the replayed context |

## Verification
A broken link or a stale tail pointer shows up at replay. The walk then presents a slot other than the one issued in the matching descriptor, or it raises `rp_last` one acknowledge too early or too late. A pool bitmap that fails to release shows up as a hold of `in_ready` on the next start-of-packet byte. A bitmap that releases too early hands out a slot number that a live packet still owns, and the next descriptor shows it one cycle after the byte. A wrong per-port byte count moves the block boundary, and this shows at once as a `d_cnt` other than 64 on a non-final descriptor.

// File: rtl/pdu_seg_pkg.sv
package pdu_seg_pkg;
    // state of the replay walker
    typedef enum logic {
        RP_IDLE,
        RP_WALK
    } rp_state_e;
endpackage

// File: rtl/seg_free_pool.sv
module seg_free_pool #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic [N-1:0]  rel_mask,
    output logic          avail,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  free_map
);
    typedef struct packed {
        logic [N-1:0] free;
    } pool_t;

    pool_t pool_d, pool_q;

    always_comb begin
        avail = |pool_q.free;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pool_q.free[i]) idx = IW'(i);
        end
        pool_d = pool_q;
        if (alloc && avail) pool_d.free[idx] = 1'b0;
        pool_d.free = pool_d.free | rel_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pool_q.free <= '1;
        else        pool_q      <= pool_d;
    end

    assign free_map = pool_q.free;

    // R7/R8: a grant is only asked for while an entry is free
    p_grant_when_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> avail);
    // R10: only held entries are handed back
    p_release_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_mask & pool_q.free) == '0);
endmodule

// File: rtl/pdu_blk_seg.sv
module pdu_blk_seg
    import pdu_seg_pkg::*;
#(
    parameter int NPORT     = 4,
    parameter int NCTX      = 64,
    parameter int NBLK      = 128,
    parameter int BLK_BYTES = 64,
    parameter int OFF_W     = 16,
    localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int CW = (NCTX > 1) ? $clog2(NCTX) : 1,
    localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1,
    localparam int KW = $clog2(BLK_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [PW-1:0]    in_port,
    output logic             in_ready,
    output logic             d_valid,
    output logic [BW-1:0]    d_blk,
    output logic [CW-1:0]    d_ctx,
    output logic [PW-1:0]    d_port,
    output logic [OFF_W-1:0] d_off,
    output logic             d_last,
    output logic [KW-1:0]    d_cnt,
    output logic [BW-1:0]    d_next,
    input  logic             rp_start,
    input  logic [CW-1:0]    rp_ctx,
    input  logic             rp_ack,
    output logic             rp_valid,
    output logic [BW-1:0]    rp_blk,
    output logic             rp_last,
    output logic [PW-1:0]    rp_port
);
    typedef struct {
        // per-port open packet
        logic [NPORT-1:0] p_open;
        logic [CW-1:0]    p_ctx [NPORT];
        logic [BW-1:0]    p_blk [NPORT];
        logic [KW-1:0]    p_cnt [NPORT];
        logic [OFF_W-1:0] p_off [NPORT];
        // per-context record
        logic [NCTX-1:0]  c_done;
        logic [PW-1:0]    c_port [NCTX];
        logic [BW-1:0]    c_head [NCTX];
        logic [BW-1:0]    c_tail [NCTX];
        // per-slot chain and owner
        logic [BW-1:0]    b_next [NBLK];
        logic [CW-1:0]    b_own  [NBLK];
        // replay walker
        rp_state_e        rp_st;
        logic [CW-1:0]    rp_c;
        logic [BW-1:0]    rp_b;
        // descriptor register
        logic             dv;
        logic [BW-1:0]    dblk;
        logic [CW-1:0]    dctx;
        logic [PW-1:0]    dport;
        logic [OFF_W-1:0] doff;
        logic             dlast;
        logic [KW-1:0]    dcnt;
        logic [BW-1:0]    dnext;
    } seg_t;

    seg_t s_d, s_q;

    logic            ctx_alloc, blk_alloc, ctx_av, blk_av;
    logic [CW-1:0]   ctx_idx;
    logic [BW-1:0]   blk_idx;
    logic [NCTX-1:0] ctx_rel, ctx_free;
    logic [NBLK-1:0] blk_rel, blk_free;

    seg_free_pool #(.N(NCTX)) u_ctx_pool (
        .clk(clk), .rst_n(rst_n), .alloc(ctx_alloc), .rel_mask(ctx_rel),
        .avail(ctx_av), .idx(ctx_idx), .free_map(ctx_free)
    );

    seg_free_pool #(.N(NBLK)) u_blk_pool (
        .clk(clk), .rst_n(rst_n), .alloc(blk_alloc), .rel_mask(blk_rel),
        .avail(blk_av), .idx(blk_idx), .free_map(blk_free)
    );

    // a byte that may close a block needs a spare slot for the chain
    logic at_edge;
    always_comb begin
        at_edge = s_q.p_cnt[in_port] == KW'(BLK_BYTES - 1);
        if (in_sop) in_ready = ctx_av && blk_av;
        else        in_ready = !at_edge || blk_av;
    end

    always_comb begin
        logic          take, work;
        logic [CW-1:0] cur_ctx;
        logic [BW-1:0] cur_blk;
        logic [OFF_W-1:0] cur_off;
        logic [KW-1:0] cnt_nx;

        s_d       = s_q;
        s_d.dv    = 1'b0;
        ctx_alloc = 1'b0;
        blk_alloc = 1'b0;
        ctx_rel   = '0;
        blk_rel   = '0;
        take      = in_valid && in_ready;
        work      = take && (in_sop || s_q.p_open[in_port]);
        cur_ctx   = s_q.p_ctx[in_port];
        cur_blk   = s_q.p_blk[in_port];
        cur_off   = s_q.p_off[in_port];
        cnt_nx    = s_q.p_cnt[in_port] + KW'(1);

        if (take && in_sop) begin
            ctx_alloc = 1'b1;
            blk_alloc = 1'b1;
            cur_ctx   = ctx_idx;
            cur_blk   = blk_idx;
            cur_off   = '0;
            cnt_nx    = KW'(1);
            s_d.p_open[in_port]  = 1'b1;
            s_d.p_ctx[in_port]   = ctx_idx;
            s_d.p_blk[in_port]   = blk_idx;
            s_d.p_off[in_port]   = '0;
            s_d.c_done[ctx_idx]  = 1'b0;
            s_d.c_port[ctx_idx]  = in_port;
            s_d.c_head[ctx_idx]  = blk_idx;
            s_d.b_own[blk_idx]   = ctx_idx;
        end

        if (work) begin
            if (in_eop || cnt_nx == KW'(BLK_BYTES)) begin
                s_d.dv    = 1'b1;
                s_d.dblk  = cur_blk;
                s_d.dctx  = cur_ctx;
                s_d.dport = in_port;
                s_d.doff  = cur_off;
                s_d.dlast = in_eop;
                s_d.dcnt  = cnt_nx;
                s_d.dnext = in_eop ? '0 : blk_idx;
            end
            if (in_eop) begin
                s_d.p_open[in_port] = 1'b0;
                s_d.p_cnt[in_port]  = '0;
                s_d.c_done[cur_ctx] = 1'b1;
                s_d.c_tail[cur_ctx] = cur_blk;
            end else if (cnt_nx == KW'(BLK_BYTES)) begin
                blk_alloc             = 1'b1;
                s_d.b_next[cur_blk]   = blk_idx;
                s_d.b_own[blk_idx]    = cur_ctx;
                s_d.p_blk[in_port]    = blk_idx;
                s_d.p_cnt[in_port]    = '0;
                s_d.p_off[in_port]    = cur_off + OFF_W'(BLK_BYTES);
            end else begin
                s_d.p_cnt[in_port]    = cnt_nx;
            end
        end

        case (s_q.rp_st)
            RP_IDLE: begin
                if (rp_start && s_q.c_done[rp_ctx]) begin
                    s_d.rp_st = RP_WALK;
                    s_d.rp_c  = rp_ctx;
                    s_d.rp_b  = s_q.c_head[rp_ctx];
                end
            end
            default: begin
                if (rp_ack) begin
                    if (s_q.rp_b == s_q.c_tail[s_q.rp_c]) begin
                        s_d.rp_st           = RP_IDLE;
                        s_d.c_done[s_q.rp_c] = 1'b0;
                        ctx_rel[s_q.rp_c]   = 1'b1;
                        for (int b = 0; b < NBLK; b++) begin
                            if (!blk_free[b] && s_q.b_own[b] == s_q.rp_c) blk_rel[b] = 1'b1;
                        end
                    end else begin
                        s_d.rp_b = s_q.b_next[s_q.rp_b];
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.p_open <= '0;
            s_q.c_done <= '0;
            s_q.rp_st  <= RP_IDLE;
            s_q.rp_c   <= '0;
            s_q.rp_b   <= '0;
            s_q.dv     <= 1'b0;
            s_q.dblk   <= '0;
            s_q.dctx   <= '0;
            s_q.dport  <= '0;
            s_q.doff   <= '0;
            s_q.dlast  <= 1'b0;
            s_q.dcnt   <= '0;
            s_q.dnext  <= '0;
            for (int i = 0; i < NPORT; i++) begin
                s_q.p_cnt[i] <= '0;
                s_q.p_off[i] <= '0;
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign d_valid  = s_q.dv;
    assign d_blk    = s_q.dblk;
    assign d_ctx    = s_q.dctx;
    assign d_port   = s_q.dport;
    assign d_off    = s_q.doff;
    assign d_last   = s_q.dlast;
    assign d_cnt    = s_q.dcnt;
    assign d_next   = s_q.dnext;
    assign rp_valid = s_q.rp_st == RP_WALK;
    assign rp_blk   = s_q.rp_b;
    assign rp_last  = s_q.rp_b == s_q.c_tail[s_q.rp_c];
    assign rp_port  = s_q.c_port[s_q.rp_c];

    // R2: a non-final block is always full
    p_full_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid && !d_last |-> d_cnt == KW'(BLK_BYTES));
    // R2: blocks start on block-sized offsets
    p_block_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid |-> (d_off % OFF_W'(BLK_BYTES)) == '0);
    // R3: a final block holds 1..BLK_BYTES bytes and links nowhere
    p_last_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid && d_last |-> d_cnt != '0 && d_cnt <= KW'(BLK_BYTES) && d_next == '0);
    // R7: a held byte leaves no descriptor behind
    p_no_desc_when_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_ready |=> !d_valid);
    // R9: a presented slot waits for its acknowledge
    p_replay_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rp_valid && !rp_ack |=> rp_valid && $stable(rp_blk));
    // R11: replay never starts on a context that is not finished
    p_replay_needs_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rp_valid && !(rp_start && s_q.c_done[rp_ctx]) |=> !rp_valid);
endmodule

// File: tb/pdu_blk_seg_tb_top.sv
module pdu_blk_seg_tb_top;
    localparam int NPORT = 4, NCTX = 4, NBLK = 8, BLK = 64, OFF_W = 16;
    localparam int PW = 2, CW = 2, BW = 3, KW = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 0, in_sop = 0, in_eop = 0, in_ready;
    logic [PW-1:0] in_port = '0;
    logic d_valid, d_last;
    logic [BW-1:0] d_blk, d_next;
    logic [CW-1:0] d_ctx;
    logic [PW-1:0] d_port;
    logic [OFF_W-1:0] d_off;
    logic [KW-1:0] d_cnt;
    logic rp_start = 0, rp_ack = 0, rp_valid, rp_last;
    logic [CW-1:0] rp_ctx = '0;
    logic [BW-1:0] rp_blk;
    logic [PW-1:0] rp_port;

    // 50 MHz: 20 time-unit period
    always #10 clk = ~clk;

    pdu_blk_seg #(.NPORT(NPORT), .NCTX(NCTX), .NBLK(NBLK), .BLK_BYTES(BLK), .OFF_W(OFF_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_port(in_port), .in_ready(in_ready), .d_valid(d_valid), .d_blk(d_blk),
        .d_ctx(d_ctx), .d_port(d_port), .d_off(d_off), .d_last(d_last), .d_cnt(d_cnt),
        .d_next(d_next), .rp_start(rp_start), .rp_ctx(rp_ctx), .rp_ack(rp_ack),
        .rp_valid(rp_valid), .rp_blk(rp_blk), .rp_last(rp_last), .rp_port(rp_port)
    );

    int nchk = 0, nfail = 0, cyc = 0;
    bit finished = 0;

    // descriptor capture
    int ncap = 0;
    int c_blk[64], c_ctx[64], c_port[64], c_off[64], c_last[64], c_cnt[64], c_next[64];
    always @(negedge clk) begin
        if (rst_n && d_valid && ncap < 64) begin
            c_blk[ncap] = int'(d_blk);  c_ctx[ncap] = int'(d_ctx); c_port[ncap] = int'(d_port);
            c_off[ncap] = int'(d_off);  c_last[ncap] = int'(d_last);
            c_cnt[ncap] = int'(d_cnt);  c_next[ncap] = int'(d_next);
            ncap = ncap + 1;
        end
    end

    task automatic chk(input int act, input int exp, input string what);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; in_valid = 0; rp_start = 0; rp_ack = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        ncap = 0;
    endtask

    task automatic put_byte(input int p, input bit s, input bit e);
        @(negedge clk);
        in_valid = 1; in_port = PW'(p); in_sop = s; in_eop = e;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 0; in_sop = 0; in_eop = 0;
        repeat (n) @(negedge clk);
    endtask

    // replay context c, expecting slots first..first+n-1 in order
    task automatic replay_seq(input int c, input int n, input int first, input int port);
        @(negedge clk);
        rp_start = 1; rp_ctx = CW'(c);
        @(negedge clk);
        rp_start = 0;
        for (int k = 0; k < n; k++) begin
            chk(int'(rp_valid), 1, "R9 rp_valid during walk");
            chk(int'(rp_blk), first + k, "R9 rp_blk order");
            chk(int'(rp_last), (k == n - 1) ? 1 : 0, "R9 rp_last");
            chk(int'(rp_port), port, "R9 rp_port");
            rp_ack = 1;
            @(negedge clk);
        end
        rp_ack = 0;
        chk(int'(rp_valid), 0, "R9 walk ends after final ack");
    endtask

    localparam int NV = 6;
    localparam int VLEN [NV] = '{1, 64, 65, 130, 63, 128};
    localparam int VPRT [NV] = '{0, 1, 2, 3, 0, 2};

    initial begin
        do_reset();
        // R1: reset state
        @(negedge clk);
        in_sop = 1; #1;
        chk(int'(d_valid), 0, "R1 d_valid after reset");
        chk(int'(rp_valid), 0, "R1 rp_valid after reset");
        chk(int'(in_ready), 1, "R1 sop accepted after reset");
        in_sop = 0;

        // table of packets: each is segmented, replayed and released
        for (int v = 0; v < NV; v++) begin
            int nb;
            nb = (VLEN[v] + BLK - 1) / BLK;
            ncap = 0;
            for (int i = 0; i < VLEN[v]; i++) put_byte(VPRT[v], i == 0, i == VLEN[v] - 1);
            idle(2);
            chk(ncap, nb, "R2 descriptor count");
            for (int k = 0; k < nb; k++) begin
                chk(c_blk[k], k, "R5 lowest free slot");
                chk(c_ctx[k], 0, "R4 lowest free context");
                chk(c_port[k], VPRT[v], "R4 port recorded");
                chk(c_off[k], k * BLK, "R2 block offset");
                chk(c_last[k], (k == nb - 1) ? 1 : 0, "R3 last flag");
                chk(c_cnt[k], (k == nb - 1) ? ((VLEN[v] - 1) % BLK) + 1 : BLK, "R3 byte count");
                chk(c_next[k], (k == nb - 1) ? 0 : k + 1, "R5 next link");
            end
            // R10: after the previous release, context 0 and slot 0 are reused
            replay_seq(0, nb, 0, VPRT[v]);
        end

        // R6: port 1 (70 bytes) and port 2 (10 bytes) interleaved byte by byte
        ncap = 0;
        begin
            int j1, j2;
            j1 = 0; j2 = 0;
            for (int i = 0; i < 80; i++) begin
                if (i < 20 && (i % 2) == 1) begin
                    put_byte(2, j2 == 0, j2 == 9); j2++;
                end else begin
                    put_byte(1, j1 == 0, j1 == 69); j1++;
                end
            end
        end
        idle(2);
        chk(ncap, 3, "R6 interleaved descriptor count");
        chk(c_ctx[0], 1, "R6 second packet context");
        chk(c_blk[0], 1, "R6 second packet slot");
        chk(c_cnt[0], 10, "R6 second packet count");
        chk(c_port[0], 2, "R6 second packet port");
        chk(c_ctx[1], 0, "R6 first packet context");
        chk(c_next[1], 2, "R5 interleaved link");
        chk(c_blk[2], 2, "R5 interleaved second slot");
        chk(c_cnt[2], 6, "R3 interleaved tail count");
        chk(c_off[2], 64, "R2 interleaved tail offset");

        // R11: replay of a free context is ignored
        @(negedge clk); rp_start = 1; rp_ctx = 2;
        @(negedge clk); rp_start = 0;
        chk(int'(rp_valid), 0, "R11 free context replay ignored");

        // contexts 2 and 3 taken by open packets on ports 0 and 3
        put_byte(0, 1, 0); put_byte(0, 0, 0);
        put_byte(3, 1, 0); put_byte(3, 0, 0);
        idle(1);
        @(negedge clk); rp_start = 1; rp_ctx = 2;
        @(negedge clk); rp_start = 0;
        chk(int'(rp_valid), 0, "R11 open context replay ignored");

        // R7: no context left for a new packet on port 1
        ncap = 0;
        @(negedge clk);
        in_valid = 1; in_port = 1; in_sop = 1; in_eop = 1;
        #1 chk(int'(in_ready), 0, "R7 held without free context");
        repeat (3) @(negedge clk);
        chk(ncap, 0, "R7 no descriptor while held");
        // replay context 0 (slots 0 then 2) while the byte is held
        rp_start = 1; rp_ctx = 0;
        @(negedge clk); rp_start = 0;
        chk(int'(rp_blk), 0, "R9 head slot");
        chk(int'(rp_last), 0, "R9 head not last");
        rp_ack = 1;
        @(negedge clk);
        chk(int'(rp_blk), 2, "R9 chained slot");
        chk(int'(rp_last), 1, "R9 tail marked");
        #1 chk(int'(in_ready), 0, "R10 still held before final ack");
        @(negedge clk);
        rp_ack = 0;
        #1 chk(int'(in_ready), 1, "R10 context free after final ack");
        @(posedge clk);
        idle(2);
        chk(ncap, 1, "R10 held packet completes");
        chk(c_ctx[0], 0, "R10 released context reused");
        chk(c_blk[0], 0, "R10 released slot reused");

        // R8: slot pool exhausted at a block boundary
        do_reset();
        ncap = 0;
        for (int i = 0; i < 8 * BLK - 1; i++) put_byte(0, i == 0, 1'b0);
        @(negedge clk);
        in_valid = 1; in_port = 0; in_sop = 0; in_eop = 1;
        #1 chk(int'(in_ready), 0, "R8 held without free slot");
        repeat (3) @(negedge clk);
        chk(ncap, 7, "R8 descriptors before the hold");
        chk(c_next[6], 7, "R5 link into last slot");
        idle(1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            nfail++;
            nchk++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule